// File: doc/BRIEF.md
# Fragment-Aware Translation Buffer

This block caches virtual-to-physical page translations in which every entry carries a fragment code. The code sets how much address space the entry spans. Code 0 spans one 4KB page. A nonzero code `f` spans `1 << (12 + f)` bytes of physically contiguous memory. One cached entry can therefore stand in for every 4KB page of a large contiguous allocation, and its flags hold for the whole span.

Storage is split into two fully associative partitions of unequal size. A small partition holds 4KB entries and a larger partition holds fragment entries. The fragment code of an incoming fill decides which partition receives it. A lookup searches both partitions in the same cycle and returns a registered result one cycle later. That result is a hit or a miss, the composed physical address and the entry's flags. A single invalidate input empties both partitions. The block does not walk page tables or service misses.

Top module: `frag_tlb`

## Requirements
- R1: After reset no entry is valid. Every lookup misses until a fill is installed, and `lk_hit`, `lk_miss`, `lk_pa` and `lk_flags` read zero until a lookup is made.
- R2: An entry matches a lookup address when the virtual page number bits at position `frag` and above are equal to the entry's virtual page number bits at the same positions. For code 0, all page-number bits must be equal.
- R3: On a hit, `lk_pa` bits below `12 + frag` are taken from the lookup address. The bits above are taken from the entry's physical page number. Low bits of the stored page numbers under the fragment are ignored.
- R4: On a hit, `lk_flags` equals the stored flags for every address inside the fragment, and bit 0 of `lk_flags` (the valid bit) is 1.
- R5: A lookup that matches nothing gives `lk_miss`=1, `lk_hit`=0, `lk_pa`=0 and `lk_flags`=0. A cycle with no lookup gives `lk_hit`=0 and `lk_miss`=0.
- R6: A fill with `fl_frag`=0 goes to the 8-entry small partition. A fill with any other code goes to the 16-entry large partition and leaves the small partition untouched, and the reverse also holds.
- R7: Within each partition, accepted fills take slots 0, 1, … N-1 in turn and then wrap to 0, replacing the entry held there. Only an accepted fill advances the slot.
- R8: A fill whose `fl_flags` bit 0 is 0 installs nothing and does not advance the replacement slot.
- R9: When both partitions hit, the result comes from the large-partition entry.
- R10: An `inval_all` pulse clears every entry, so that lookups made in the next cycle miss. It returns both replacement slots to 0 and overrides a fill in the same cycle.
- R11: The result of a lookup issued in one cycle appears on the outputs after the next rising edge. A lookup issued in the same cycle as a fill sees the contents from before that fill.
- R12: When several entries of one partition match, the entry in the lowest slot supplies the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request this cycle |
| lk_va | input | 32 | Lookup virtual address |
| fl_en | input | 1 | Fill request this cycle |
| fl_vpn | input | 20 | Fill virtual page number (address bits 31:12) |
| fl_ppn | input | 20 | Fill physical page number (address bits 31:12) |
| fl_frag | input | 4 | Fill fragment code; 0 = 4KB |
| fl_flags | input | 4 | Fill flags; bit 0 is the valid bit |
| inval_all | input | 1 | Clear every entry |
| lk_hit | output | 1 | Registered lookup hit |
| lk_miss | output | 1 | Registered lookup miss |
| lk_pa | output | 32 | Registered physical address, zero on miss |
| lk_flags | output | 4 | Registered flags, zero on miss |

## Verification
Errors in internal state show up at the outputs one cycle after the lookup that reads them. A stale valid bit shows as a hit where a miss is expected. A wrong fragment mask shows either as a miss at the upper edge of a fragment or as a hit one byte past it. A replacement slot that is off by one shows as the wrong victim when the partition wraps. Because all of these stay in storage until the next accepted fill or invalidate, the bench probes every installed entry at its base, at its last byte and one past its last byte after each wrap. It also probes after each invalidate, so that a fault is caught within a few lookups of the state going wrong.

// File: rtl/ftlb_pkg.sv
package ftlb_pkg;
  localparam int VA_W   = 32;
  localparam int PA_W   = 32;
  localparam int OFS_W  = 12;
  localparam int FRAG_W = 4;
  localparam int FLAG_W = 4;
  localparam int VPN_W  = VA_W - OFS_W;
  localparam int PPN_W  = PA_W - OFS_W;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [PPN_W-1:0]  ppn;
    logic [FRAG_W-1:0] frag;
    logic [FLAG_W-1:0] flags;
  } ftlb_entry_t;

  // Page-number bits that lie inside the fragment (ones below bit 'f').
  function automatic logic [VPN_W-1:0] frag_mask(input logic [FRAG_W-1:0] f);
    return (VPN_W'(1) << f) - VPN_W'(1);
  endfunction

  function automatic logic frag_match(input logic [VPN_W-1:0] a,
                                      input logic [VPN_W-1:0] b,
                                      input logic [FRAG_W-1:0] f);
    return ((a ^ b) & ~frag_mask(f)) == '0;
  endfunction

  // Physical page: upper bits from the entry, in-fragment bits from the lookup.
  function automatic logic [PPN_W-1:0] frag_ppn(input logic [PPN_W-1:0] ppn,
                                                input logic [VPN_W-1:0] vpn,
                                                input logic [FRAG_W-1:0] f);
    logic [PPN_W-1:0] m;
    m = PPN_W'(frag_mask(f));
    return (ppn & ~m) | (PPN_W'(vpn) & m);
  endfunction
endpackage

// File: rtl/ftlb_rr_ptr.sv
module ftlb_rr_ptr #(
  parameter int N = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  always_ff @(posedge clk) begin
    if (!rst_n || clr)  ptr <= '0;
    else if (adv)       ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

  // R10
  ptr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ptr == '0);
  // R7
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clr) |=> $stable(ptr));
  // R7
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= LAST);
endmodule

// File: rtl/ftlb_part.sv
module ftlb_part
  import ftlb_pkg::*;
#(
  parameter int N = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              we,
  input  ftlb_entry_t       wr_ent,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              hit,
  output logic [PPN_W-1:0]  hit_ppn,
  output logic [FRAG_W-1:0] hit_frag,
  output logic [FLAG_W-1:0] hit_flags
);
  ftlb_entry_t      ent [N];
  logic [N-1:0]     vld;
  logic [N-1:0]     match;
  logic [IDX_W-1:0] ptr;
  logic             install;

  assign install = we && !clr;

  ftlb_rr_ptr #(.N(N)) u_ptr (
    .clk(clk), .rst_n(rst_n), .clr(clr), .adv(install), .ptr(ptr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || clr) vld <= '0;
    else if (install)  vld[ptr] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (install) ent[ptr] <= wr_ent;
  end

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = vld[g] && frag_match(ent[g].vpn, lk_vpn, ent[g].frag);
  end

  // Lowest matching slot wins: scan downward so it is assigned last.
  always_comb begin
    hit       = |match;
    hit_ppn   = '0;
    hit_frag  = '0;
    hit_flags = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_ppn   = ent[i].ppn;
        hit_frag  = ent[i].frag;
        hit_flags = ent[i].flags;
      end
    end
  end

  // R10
  part_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> vld == '0);
  // R7
  part_install_chk: assert property (@(posedge clk) disable iff (!rst_n)
    install |=> vld[$past(ptr)]);
  // R8
  part_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!we && !clr) |=> $stable(vld));
endmodule

// File: rtl/frag_tlb.sv
module frag_tlb
  import ftlb_pkg::*;
#(
  parameter int SMALL_N = 8,
  parameter int LARGE_N = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_req,
  input  logic [VA_W-1:0]   lk_va,
  input  logic              fl_en,
  input  logic [VPN_W-1:0]  fl_vpn,
  input  logic [PPN_W-1:0]  fl_ppn,
  input  logic [FRAG_W-1:0] fl_frag,
  input  logic [FLAG_W-1:0] fl_flags,
  input  logic              inval_all,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic [PA_W-1:0]   lk_pa,
  output logic [FLAG_W-1:0] lk_flags
);
  ftlb_entry_t       fill_ent;
  logic              fill_ok, sm_we, lg_we;
  logic [VPN_W-1:0]  lk_vpn;
  logic              sm_hit, lg_hit, any_hit;
  logic [PPN_W-1:0]  sm_ppn, lg_ppn;
  logic [FRAG_W-1:0] sm_frag, lg_frag;
  logic [FLAG_W-1:0] sm_flags, lg_flags;
  logic [PA_W-1:0]   sm_pa_w, lg_pa_w, pa_nxt;
  logic [FLAG_W-1:0] flags_nxt;

  assign fill_ent = '{vpn: fl_vpn, ppn: fl_ppn, frag: fl_frag, flags: fl_flags};
  assign fill_ok  = fl_en && fl_flags[0];
  assign sm_we    = fill_ok && (fl_frag == '0);
  assign lg_we    = fill_ok && (fl_frag != '0);
  assign lk_vpn   = lk_va[VA_W-1:OFS_W];

  ftlb_part #(.N(SMALL_N)) u_small (
    .clk(clk), .rst_n(rst_n), .clr(inval_all), .we(sm_we), .wr_ent(fill_ent),
    .lk_vpn(lk_vpn), .hit(sm_hit), .hit_ppn(sm_ppn), .hit_frag(sm_frag),
    .hit_flags(sm_flags)
  );

  ftlb_part #(.N(LARGE_N)) u_large (
    .clk(clk), .rst_n(rst_n), .clr(inval_all), .we(lg_we), .wr_ent(fill_ent),
    .lk_vpn(lk_vpn), .hit(lg_hit), .hit_ppn(lg_ppn), .hit_frag(lg_frag),
    .hit_flags(lg_flags)
  );

  assign sm_pa_w   = {frag_ppn(sm_ppn, lk_vpn, sm_frag), lk_va[OFS_W-1:0]};
  assign lg_pa_w   = {frag_ppn(lg_ppn, lk_vpn, lg_frag), lk_va[OFS_W-1:0]};
  assign any_hit   = sm_hit || lg_hit;
  assign pa_nxt    = lg_hit ? lg_pa_w  : sm_pa_w;
  assign flags_nxt = lg_hit ? lg_flags : sm_flags;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_hit   <= 1'b0;
      lk_miss  <= 1'b0;
      lk_pa    <= '0;
      lk_flags <= '0;
    end else begin
      lk_hit   <= lk_req && any_hit;
      lk_miss  <= lk_req && !any_hit;
      lk_pa    <= (lk_req && any_hit) ? pa_nxt : '0;
      lk_flags <= (lk_req && any_hit) ? flags_nxt : '0;
    end
  end

  // R5
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_miss));
  // R5
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |-> (lk_pa == '0 && lk_flags == '0));
  // R11
  resp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit || lk_miss) |-> $past(lk_req));
  // R4
  hit_valid_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_flags[0]);
  // R9
  large_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lk_req && sm_hit && lg_hit) |-> (lk_pa == $past(lg_pa_w)));
endmodule

// File: tb/frag_tlb_test.sv
module frag_tlb_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_req = 1'b0;
  logic [31:0] lk_va = '0;
  logic        fl_en = 1'b0;
  logic [19:0] fl_vpn = '0;
  logic [19:0] fl_ppn = '0;
  logic [3:0]  fl_frag = '0;
  logic [3:0]  fl_flags = '0;
  logic        inval_all = 1'b0;
  logic        lk_hit, lk_miss;
  logic [31:0] lk_pa;
  logic [3:0]  lk_flags;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Bench model: addresses stored as full byte addresses.
  logic [31:0] s_va [8];  logic [31:0] s_pa [8];  logic [3:0] s_fl [8];  bit s_v [8];
  logic [31:0] l_va [16]; logic [31:0] l_pa [16]; logic [3:0] l_fl [16]; bit l_v [16];
  logic [3:0]  l_fr [16];
  int s_ptr = 0, l_ptr = 0;

  frag_tlb uut (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_va(lk_va), .fl_en(fl_en),
    .fl_vpn(fl_vpn), .fl_ppn(fl_ppn), .fl_frag(fl_frag), .fl_flags(fl_flags),
    .inval_all(inval_all), .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_pa(lk_pa),
    .lk_flags(lk_flags)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Result packed as {hit, miss, pa, flags}.
  function automatic logic [37:0] expect_lookup(input logic [31:0] va);
    int sh;
    logic [31:0] lo;
    for (int i = 0; i < 16; i++) begin
      sh = 12 + int'(l_fr[i]);
      if (l_v[i] && ((va >> sh) == (l_va[i] >> sh))) begin
        lo = (32'h1 << sh) - 32'h1;
        return {2'b10, ((l_pa[i] >> sh) << sh) | (va & lo), l_fl[i]};
      end
    end
    for (int i = 0; i < 8; i++) begin
      if (s_v[i] && ((va >> 12) == (s_va[i] >> 12)))
        return {2'b10, {s_pa[i][31:12], va[11:0]}, s_fl[i]};
    end
    return {2'b01, 32'h0, 4'h0};
  endfunction

  task automatic model_fill(input logic [31:0] va, input logic [31:0] pa,
                            input logic [3:0] fr, input logic [3:0] fl);
    if (!fl[0]) return;
    if (fr == 4'd0) begin
      s_va[s_ptr] = va; s_pa[s_ptr] = pa; s_fl[s_ptr] = fl; s_v[s_ptr] = 1;
      s_ptr = (s_ptr + 1) % 8;
    end else begin
      l_va[l_ptr] = va; l_pa[l_ptr] = pa; l_fl[l_ptr] = fl; l_fr[l_ptr] = fr;
      l_v[l_ptr] = 1; l_ptr = (l_ptr + 1) % 16;
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 8; i++)  s_v[i] = 0;
    for (int i = 0; i < 16; i++) l_v[i] = 0;
    s_ptr = 0; l_ptr = 0;
  endtask

  task automatic do_fill(input logic [31:0] va, input logic [31:0] pa,
                         input logic [3:0] fr, input logic [3:0] fl);
    fl_en = 1; fl_vpn = va[31:12]; fl_ppn = pa[31:12]; fl_frag = fr; fl_flags = fl;
    @(negedge clk);
    fl_en = 0;
    model_fill(va, pa, fr, fl);
  endtask

  task automatic do_inval();
    inval_all = 1;
    @(negedge clk);
    inval_all = 0;
    model_clear();
  endtask

  task automatic probe(input string req, input logic [31:0] va);
    logic [37:0] e;
    e = expect_lookup(va);
    lk_req = 1; lk_va = va;
    @(negedge clk);
    lk_req = 0;
    chk(req, {26'h0, lk_hit, lk_miss, lk_pa, lk_flags}, {26'h0, e});
  endtask

  // Probe the edges and interior of a region of 2^sh bytes around va.
  task automatic probe_region(input string req, input logic [31:0] va, input int sh);
    logic [31:0] base, sz;
    sz = 32'h1 << sh;
    base = va & ~(sz - 32'h1);
    probe(req, base);
    probe(req, base + sz - 32'h1);
    probe(req, base + (sz >> 1) + 32'h123);
    probe(req, base + sz);
    probe(req, base - 32'h1);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state and empty storage
    chk("R1 reset outputs", {lk_hit, lk_miss, lk_pa, lk_flags}, 38'h0);
    probe("R1 empty lookup", 32'h1234_5678);
    // R5: idle cycle with no lookup
    @(negedge clk);
    chk("R5 idle outputs", {lk_hit, lk_miss}, 2'b00);

    // R8: fill with valid bit clear is dropped
    do_fill(32'h2000_0000, 32'h7000_0000, 4'd0, 4'hE);
    do_fill(32'h2100_0000, 32'h7100_0000, 4'd3, 4'hA);
    probe("R8 dropped small fill", 32'h2000_0010);
    probe("R8 dropped large fill", 32'h2100_0010);

    // R2 R3 R4 R6: sweep both partitions full
    for (int i = 0; i < 8; i++)
      do_fill(32'h1000_0000 + i * 32'h3000, 32'h8000_0000 + i * 32'h1_0000,
              4'd0, {i[2:0], 1'b1});
    for (int i = 0; i < 16; i++)
      do_fill(32'h4000_0000 + i * 32'h0100_0000 + 32'h5000,
              32'h9000_0000 + i * 32'h0020_0000 + 32'h3000,
              4'((i % 8) + 1), {i[2:0], 1'b1});
    for (int i = 0; i < 8; i++)
      probe_region("R2 R3 small sweep", s_va[i], 12);
    for (int i = 0; i < 16; i++)
      probe_region("R2 R3 R4 large sweep", l_va[i], 12 + int'(l_fr[i]));

    // R6 R7: ninth small fill evicts slot 0, large partition untouched
    do_fill(32'h1800_0000, 32'h8800_0000, 4'd0, 4'h3);
    chk("R7 small victim slot", {31'h0, s_v[0] && s_va[0] == 32'h1800_0000}, 64'h1);
    probe("R7 evicted small entry misses", 32'h1000_0000);
    probe("R7 slot1 small entry kept", 32'h1000_3000);
    probe("R6 new small entry", 32'h1800_0ABC);
    for (int i = 0; i < 16; i++)
      probe("R6 large unaffected by small fill", l_va[i]);

    // R9: large fragment overlapping small entries wins
    do_fill(32'h1000_0000, 32'hA000_0000, 4'd4, 4'h5);
    for (int i = 1; i < 6; i++)
      probe("R9 large priority", 32'h1000_0000 + i * 32'h3000 + 32'h44);
    probe("R7 large victim slot0", 32'h4000_5000);

    // R11: lookup in the fill cycle sees old contents
    lk_req = 1; lk_va = 32'h3300_0100;
    fl_en = 1; fl_vpn = 20'h33000; fl_ppn = 20'hB3000; fl_frag = 4'd0; fl_flags = 4'h1;
    @(negedge clk);
    lk_req = 0; fl_en = 0;
    chk("R11 lookup during fill", {lk_hit, lk_miss, lk_pa}, {2'b01, 32'h0});
    model_fill(32'h3300_0000, 32'hB300_0000, 4'd0, 4'h1);
    probe("R11 lookup after fill", 32'h3300_0100);

    // R10: invalidate with a concurrent fill
    inval_all = 1;
    fl_en = 1; fl_vpn = 20'h55000; fl_ppn = 20'hC5000; fl_frag = 4'd0; fl_flags = 4'h1;
    @(negedge clk);
    inval_all = 0; fl_en = 0;
    model_clear();
    probe("R10 small cleared", 32'h1800_0000);
    probe("R10 large cleared", 32'h4100_5000);
    probe("R10 concurrent fill dropped", 32'h5500_0000);

    // R10 R7: pointers back at slot 0 after invalidate
    for (int i = 0; i < 9; i++)
      do_fill(32'h6000_0000 + i * 32'h1000, 32'h6100_0000 + i * 32'h2000, 4'd0, 4'h1);
    probe("R10 pointer restart evicts first", 32'h6000_0000);
    for (int i = 1; i < 9; i++)
      probe("R10 pointer restart keeps rest", 32'h6000_0000 + i * 32'h1000);

    // R12: duplicate matches, lowest slot wins
    do_inval();
    do_fill(32'h7700_0000, 32'hD100_0000, 4'd0, 4'h3);
    do_fill(32'h7700_0000, 32'hD200_0000, 4'd0, 4'h5);
    lk_req = 1; lk_va = 32'h7700_0042;
    @(negedge clk);
    lk_req = 0;
    chk("R12 lowest slot wins", {lk_hit, lk_pa, lk_flags}, {1'b1, 32'hD100_0042, 4'h3});
    do_fill(32'h7780_0000, 32'hE000_0000, 4'd2, 4'h7);
    do_fill(32'h7780_2000, 32'hF000_0000, 4'd1, 4'h9);
    lk_req = 1; lk_va = 32'h7780_2abc;
    @(negedge clk);
    lk_req = 0;
    chk("R12 R3 large lowest slot", {lk_hit, lk_pa, lk_flags}, {1'b1, 32'hE000_2abc, 4'h7});

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule